// File: doc/BRIEF.md
# Register Wakeup Dependency Tracker

This block sits beside an instruction queue and records which queue slots are still waiting for a physical register to be written. Integer and floating-point physical registers share one index space. Integer tags come first and float tags follow them, so with 32 of each, tags 0 to 31 are integer and 32 to 63 are float. A per-register ready bit, the scoreboard, shows whether each register's value exists yet.

Rename drives the allocate port when it names a register as some instruction's destination. Dispatch drives the insert port with a queue slot and two source tags. Any source whose ready bit is clear enrolls the slot in that register's dependent vector. Writeback drives the completion port. The completion sets the register's ready bit and empties its dependent vector in a single cycle. Every slot that has then lost its last outstanding source appears in the registered wake vector one cycle later. A squash mask removes slots from every dependent vector at once.

Top module: `regwake_tracker`

## Requirements
- R1: Reset sets every ready bit to 1, empties every dependent vector and drives wake to 0. A consumer inserted after reset is therefore woken at once, and a completion then wakes nothing that was enrolled before the reset.
- R2: Tags 0 to INT_REGS-1 name integer registers and tags INT_REGS to INT_REGS+FP_REGS-1 name float registers. All of them behave alike, including the highest tag.
- R3: An allocation clears the ready bit of its register. A consumer inserted later with that register as a source is enrolled and is not woken.
- R4: A completion sets the ready bit of its register and empties that register's dependent vector.
- R5: A consumer whose two sources are both ready at insert has bit `ins_slot` of `wake` set in the cycle after the insert.
- R6: A consumer with two outstanding sources is woken only after both have completed.
- R7: When an insert names the register being completed in the same cycle, the completion wins. The source counts as ready and the slot is not enrolled.
- R8: A squash removes the masked slots from all dependent vectors, and none of them is woken. A squash of the slot being inserted in the same cycle also wins, so that slot is neither enrolled nor woken.
- R9: When an allocation and a completion name the same register in the same cycle, the allocation wins and the ready bit ends at 0.
- R10: Each wake is a pulse of one cycle, set one clock edge after the event that caused it.
- R11: One completion wakes every slot waiting only on that register, all in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 1 | Producer allocation valid |
| alloc_reg | input | RW | Destination tag being allocated |
| ins_vld | input | 1 | Consumer insert valid |
| ins_slot | input | SW | Queue slot of the consumer |
| ins_src0 | input | RW | First source tag |
| ins_src1 | input | RW | Second source tag |
| cmp_vld | input | 1 | Completion valid |
| cmp_reg | input | RW | Destination tag that completed |
| sqsh_vld | input | 1 | Squash valid |
| sqsh_mask | input | SLOTS | Slots to remove |
| wake | output | SLOTS | Slots whose last outstanding source became available |

## Verification
The checks assume that an insert names a slot that is not already enrolled, that every tag is below INT_REGS+FP_REGS, and that a consumer's producer was allocated in an earlier cycle than the consumer's insert. The stimulus table follows these rules. Every slot is squashed or woken before it is reused, and every register is allocated at least one cycle before the insert that depends on it. The only same-cycle collisions the bench drives are the ones R7, R8 and R9 define.

// File: rtl/regwake_pkg.sv
package regwake_pkg;
   localparam int DEF_INT_REGS = 32;
   localparam int DEF_FP_REGS  = 32;
   localparam int DEF_SLOTS    = 16;

   // index width that is never zero
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/regwake_sboard.sv
module regwake_sboard #(
   parameter int NREGS = 64,
   parameter int RW    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_vld,
   input  logic [RW-1:0]    alloc_reg,
   input  logic             cmp_vld,
   input  logic [RW-1:0]    cmp_reg,
   input  logic [RW-1:0]    src0,
   input  logic [RW-1:0]    src1,
   output logic             src0_rdy,
   output logic             src1_rdy,
   output logic [NREGS-1:0] ready_vec
);
   logic [NREGS-1:0] sb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sb_q <= '1;
      end else begin
         for (int r = 0; r < NREGS; r++) begin
            if (alloc_vld && (int'(alloc_reg) == r))
               sb_q[r] <= 1'b0;
            else if (cmp_vld && (int'(cmp_reg) == r))
               sb_q[r] <= 1'b1;
         end
      end
   end

   // the completion of this cycle is visible to an insert of this cycle
   always_comb begin
      src0_rdy = (cmp_vld && (cmp_reg == src0)) ||
                 ((int'(src0) < NREGS) && sb_q[src0]);
      src1_rdy = (cmp_vld && (cmp_reg == src1)) ||
                 ((int'(src1) < NREGS) && sb_q[src1]);
   end

   assign ready_vec = sb_q;
endmodule

// File: rtl/regwake_deplist.sv
module regwake_deplist #(
   parameter int NREGS  = 64,
   parameter int NSLOTS = 16,
   parameter int RW     = 6,
   parameter int SW     = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ins_vld,
   input  logic [SW-1:0]           ins_slot,
   input  logic [RW-1:0]           src0,
   input  logic [RW-1:0]           src1,
   input  logic                    src0_rdy,
   input  logic                    src1_rdy,
   input  logic                    cmp_vld,
   input  logic [RW-1:0]           cmp_reg,
   input  logic                    sq_vld,
   input  logic [NSLOTS-1:0]       sq_mask,
   output logic [NSLOTS-1:0]       kill,
   output logic [NSLOTS-1:0]       ins_live,
   output logic [NSLOTS-1:0]       pend_now,
   output logic [NSLOTS-1:0]       pend_next,
   output logic [NREGS*NSLOTS-1:0] dep_flat
);
   logic [NSLOTS-1:0] dep_q   [NREGS];
   logic [NSLOTS-1:0] dep_nxt [NREGS];

   always_comb begin
      kill     = sq_vld ? sq_mask : '0;
      ins_live = '0;
      if (ins_vld) ins_live[ins_slot] = 1'b1;
      ins_live = ins_live & ~kill;
   end

   always_comb begin
      pend_now  = '0;
      pend_next = '0;
      for (int r = 0; r < NREGS; r++) begin
         dep_nxt[r] = dep_q[r] & ~kill;
         if (cmp_vld && (int'(cmp_reg) == r))
            dep_nxt[r] = '0;
         if (((int'(src0) == r) && !src0_rdy) || ((int'(src1) == r) && !src1_rdy))
            dep_nxt[r] = dep_nxt[r] | ins_live;
         pend_now  = pend_now  | dep_q[r];
         pend_next = pend_next | dep_nxt[r];
         dep_flat[r*NSLOTS +: NSLOTS] = dep_q[r];
      end
   end

   always_ff @(posedge clk) begin
      for (int r = 0; r < NREGS; r++)
         dep_q[r] <= rst_n ? dep_nxt[r] : '0;
   end
endmodule

// File: rtl/regwake_wake.sv
module regwake_wake #(
   parameter int NSLOTS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSLOTS-1:0] pend_now,
   input  logic [NSLOTS-1:0] pend_next,
   input  logic [NSLOTS-1:0] ins_live,
   input  logic [NSLOTS-1:0] kill,
   output logic [NSLOTS-1:0] wake
);
   logic [NSLOTS-1:0] wake_d;

   for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
      assign wake_d[s] = !pend_next[s] && (pend_now[s] || ins_live[s]) && !kill[s];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) wake <= '0;
      else        wake <= wake_d;
   end
endmodule

// File: rtl/regwake_tracker.sv
module regwake_tracker
   import regwake_pkg::*;
#(
   parameter int INT_REGS = DEF_INT_REGS,
   parameter int FP_REGS  = DEF_FP_REGS,
   parameter int SLOTS    = DEF_SLOTS,
   localparam int NREGS   = INT_REGS + FP_REGS,
   localparam int RW      = idx_w(NREGS),
   localparam int SW      = idx_w(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_vld,
   input  logic [RW-1:0]    alloc_reg,
   input  logic             ins_vld,
   input  logic [SW-1:0]    ins_slot,
   input  logic [RW-1:0]    ins_src0,
   input  logic [RW-1:0]    ins_src1,
   input  logic             cmp_vld,
   input  logic [RW-1:0]    cmp_reg,
   input  logic             sqsh_vld,
   input  logic [SLOTS-1:0] sqsh_mask,
   output logic [SLOTS-1:0] wake
);
   if (INT_REGS < 1 || FP_REGS < 0) begin : g_bad_regs
      $error("regwake_tracker: register counts out of range");
   end
   if (SLOTS < 2) begin : g_bad_slots
      $error("regwake_tracker: at least two slots required");
   end

   logic                   s0_rdy, s1_rdy;
   logic [NREGS-1:0]       ready_vec;
   logic [SLOTS-1:0]       kill, ins_live, pend_now, pend_next;
   logic [NREGS*SLOTS-1:0] dep_flat;

   regwake_sboard #(.NREGS(NREGS), .RW(RW)) u_sb (
      .clk(clk), .rst_n(rst_n),
      .alloc_vld(alloc_vld), .alloc_reg(alloc_reg),
      .cmp_vld(cmp_vld), .cmp_reg(cmp_reg),
      .src0(ins_src0), .src1(ins_src1),
      .src0_rdy(s0_rdy), .src1_rdy(s1_rdy),
      .ready_vec(ready_vec)
   );

   regwake_deplist #(.NREGS(NREGS), .NSLOTS(SLOTS), .RW(RW), .SW(SW)) u_dep (
      .clk(clk), .rst_n(rst_n),
      .ins_vld(ins_vld), .ins_slot(ins_slot),
      .src0(ins_src0), .src1(ins_src1),
      .src0_rdy(s0_rdy), .src1_rdy(s1_rdy),
      .cmp_vld(cmp_vld), .cmp_reg(cmp_reg),
      .sq_vld(sqsh_vld), .sq_mask(sqsh_mask),
      .kill(kill), .ins_live(ins_live),
      .pend_now(pend_now), .pend_next(pend_next),
      .dep_flat(dep_flat)
   );

   regwake_wake #(.NSLOTS(SLOTS)) u_wk (
      .clk(clk), .rst_n(rst_n),
      .pend_now(pend_now), .pend_next(pend_next),
      .ins_live(ins_live), .kill(kill),
      .wake(wake)
   );
endmodule

// File: rtl/regwake_chk.sv
module regwake_chk #(
   parameter int NREGS  = 64,
   parameter int NSLOTS = 16,
   parameter int RW     = 6,
   parameter int SW     = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    alloc_vld,
   input logic [RW-1:0]           alloc_reg,
   input logic                    ins_vld,
   input logic [SW-1:0]           ins_slot,
   input logic                    cmp_vld,
   input logic [RW-1:0]           cmp_reg,
   input logic                    sqsh_vld,
   input logic [NSLOTS-1:0]       sqsh_mask,
   input logic [NSLOTS-1:0]       wake,
   input logic                    s0_rdy,
   input logic                    s1_rdy,
   input logic [NSLOTS-1:0]       pend_now,
   input logic [NREGS-1:0]        ready_vec,
   input logic [NREGS*NSLOTS-1:0] dep_flat
);
   AST_SQSH_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
      sqsh_vld |=> ((wake & $past(sqsh_mask)) == '0)); // R8

   AST_READY_INSERT_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_vld && s0_rdy && s1_rdy && !pend_now[ins_slot] &&
       !(sqsh_vld && sqsh_mask[ins_slot])) |=> wake[$past(ins_slot)]); // R5

   AST_CMP_EMPTIES_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_vld && (int'(cmp_reg) < NREGS)) |=>
      (dep_flat[int'($past(cmp_reg))*NSLOTS +: NSLOTS] == '0)); // R4

   AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_vld && (int'(alloc_reg) < NREGS)) |=> !ready_vec[$past(alloc_reg)]); // R9

   AST_CMP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_vld && (int'(cmp_reg) < NREGS) && !(alloc_vld && alloc_reg == cmp_reg))
      |=> ready_vec[$past(cmp_reg)]); // R4
endmodule

bind regwake_tracker regwake_chk #(
   .NREGS(NREGS), .NSLOTS(SLOTS), .RW(RW), .SW(SW)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .alloc_vld(alloc_vld), .alloc_reg(alloc_reg),
   .ins_vld(ins_vld), .ins_slot(ins_slot),
   .cmp_vld(cmp_vld), .cmp_reg(cmp_reg),
   .sqsh_vld(sqsh_vld), .sqsh_mask(sqsh_mask),
   .wake(wake), .s0_rdy(s0_rdy), .s1_rdy(s1_rdy),
   .pend_now(pend_now), .ready_vec(ready_vec), .dep_flat(dep_flat)
);

// File: tb/regwake_tracker_test.sv
module regwake_tracker_test;
   localparam int NV = 27;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        alloc_vld = 1'b0;
   logic [5:0]  alloc_reg = '0;
   logic        ins_vld = 1'b0;
   logic [3:0]  ins_slot = '0;
   logic [5:0]  ins_src0 = '0;
   logic [5:0]  ins_src1 = '0;
   logic        cmp_vld = 1'b0;
   logic [5:0]  cmp_reg = '0;
   logic        sqsh_vld = 1'b0;
   logic [15:0] sqsh_mask = '0;
   logic [15:0] wake;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   regwake_tracker #(.INT_REGS(32), .FP_REGS(32), .SLOTS(16)) uut (
      .clk(clk), .rst_n(rst_n),
      .alloc_vld(alloc_vld), .alloc_reg(alloc_reg),
      .ins_vld(ins_vld), .ins_slot(ins_slot),
      .ins_src0(ins_src0), .ins_src1(ins_src1),
      .cmp_vld(cmp_vld), .cmp_reg(cmp_reg),
      .sqsh_vld(sqsh_vld), .sqsh_mask(sqsh_mask),
      .wake(wake)
   );

   function automatic logic [63:0] mk(input bit av, input int ar, input bit iv,
      input int is, input int s0, input int s1, input bit cv, input int cr,
      input bit qv, input int qm, input int ex);
      return {av, 6'(ar), iv, 4'(is), 6'(s0), 6'(s1), cv, 6'(cr),
              qv, 16'(qm), 16'(ex)};
   endfunction

   localparam logic [63:0] VEC [NV] = '{
      mk(1, 5,0, 0, 0, 0,0, 0,0,0,     0),      // R3 alloc r5
      mk(1,40,0, 0, 0, 0,0, 0,0,0,     0),      // R2 alloc float r40
      mk(0, 0,1, 3, 5, 0,0, 0,0,0,     0),      // R3 slot3 waits on r5
      mk(0, 0,1, 4, 5,40,0, 0,0,0,     0),      // R6 slot4 waits on r5 and r40
      mk(0, 0,1, 7, 1, 2,0, 0,0,0,     16'h0080), // R5 ready at insert
      mk(0, 0,0, 0, 0, 0,1, 5,0,0,     16'h0008), // R4 R6 R10 r5 done
      mk(0, 0,0, 0, 0, 0,1,40,0,0,     16'h0010), // R2 R6 r40 done
      mk(1,10,0, 0, 0, 0,0, 0,0,0,     0),
      mk(0, 0,1, 1,10,10,0, 0,0,0,     0),
      mk(0, 0,1, 2,10, 3,0, 0,0,0,     0),
      mk(0, 0,0, 0, 0, 0,1,10,0,0,     16'h0006), // R11 two woken at once
      mk(1,20,0, 0, 0, 0,0, 0,0,0,     0),
      mk(0, 0,1, 5,20, 0,1,20,0,0,     16'h0020), // R7 completion wins
      mk(1,20,0, 0, 0, 0,0, 0,0,0,     0),
      mk(0, 0,1, 6,20, 0,0, 0,0,0,     0),
      mk(0, 0,1, 8,20, 0,0, 0,0,0,     0),
      mk(0, 0,0, 0, 0, 0,0, 0,1,16'h0040, 0),   // R8 squash slot6
      mk(0, 0,0, 0, 0, 0,1,20,0,0,     16'h0100), // R7 R8 only slot8
      mk(1,30,0, 0, 0, 0,1,30,0,0,     0),      // R9 alloc beats completion
      mk(0, 0,1, 9,30, 0,0, 0,0,0,     0),      // R9 r30 not ready
      mk(0, 0,0, 0, 0, 0,1,30,0,0,     16'h0200), // R9
      mk(0, 0,1,11, 1, 1,0, 0,1,16'h0800, 0),   // R8 squash beats insert
      mk(1,63,0, 0, 0, 0,0, 0,0,0,     0),      // R2 top tag
      mk(0, 0,1,15,63, 0,0, 0,0,0,     0),
      mk(0, 0,0, 0, 0, 0,1,63,0,0,     16'h8000), // R2
      mk(0, 0,1, 0, 0,62,0, 0,0,0,     16'h0001), // R5 slot0
      mk(0, 0,0, 0, 0, 0,0, 0,0,0,     0)       // R10 idle
   };

   task automatic drive(input logic [63:0] v);
      alloc_vld = v[63]; alloc_reg = v[62:57];
      ins_vld   = v[56]; ins_slot  = v[55:52];
      ins_src0  = v[51:46]; ins_src1 = v[45:40];
      cmp_vld   = v[39]; cmp_reg   = v[38:33];
      sqsh_vld  = v[32]; sqsh_mask = v[31:16];
   endtask

   task automatic check(input string req, input logic [15:0] exp);
      n_chk++;
      if (wake !== exp) begin
         n_bad++;
         $display("FAIL %s: wake=%h expected=%h", req, wake, exp);
      end
   endtask

   task automatic step(input logic [63:0] v, input string req);
      drive(v);
      @(negedge clk);
      check(req, v[15:0]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", 16'h0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i]);
         @(negedge clk);
         n_chk++;
         if (wake !== VEC[i][15:0]) begin
            n_bad++;
            $display("FAIL vector %0d (see table R tag): wake=%h expected=%h",
                     i, wake, VEC[i][15:0]);
         end
      end

      // R1: reset in mid-run drops enrollment and restores ready bits
      step(mk(1,12,0,0,0,0,0,0,0,0,0), "R1 alloc r12");
      step(mk(0,0,1,3,12,12,0,0,0,0,0), "R1 slot3 enrolled");
      drive('0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 wake held low in reset", 16'h0);
      rst_n = 1'b1;
      step(mk(0,0,1,3,12,12,0,0,0,0,16'h0008), "R1 r12 ready after reset");
      step(mk(0,0,0,0,0,0,1,12,0,0,0), "R1 no stale dependents");
      step('0, "R10 pulse ended");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule